// File: doc/BRIEF.md
# Pipeline Ring Phase Sequencer

This block sequences one producer and one consumer around a fixed ring of buffer stages. Each stage owns two completion objects. The "filled" object completes a round when the producer commits data into that stage. The "drained" object completes a round when the consumer releases the stage. Each object is modelled as a single phase bit that toggles on every completed round. The data buffers themselves sit outside the block; only the stage numbers leave it.

Each side walks a logical iteration count around the ring. The stage number advances by one per granted handshake and wraps to zero after the last stage. Each side also keeps one expected-phase bit per stage and inverts it each time a wait on that stage is granted. A wait passes only while the stage's object phase differs from the side's expected phase. The producer starts with every expected bit at 1 and the consumer starts with every expected bit at 0. Because all object phases reset to 0, the producer's first lap passes at once, while the consumer waits for the first commit. Commits and releases retire stages in the order they were granted.

Top module: `ring_phase_seq`

## Requirements
- R1: After reset, the producer acquire-ready is 1, the consumer wait-ready is 0, both stage outputs are 0 and `early_release` is 0.
- R2: Each side's stage output advances by one on each of its granted handshakes (valid and ready both 1 at a clock edge). It wraps from NUM_STAGES-1 to 0 and holds its value when nothing is granted.
- R3: On the first lap after reset, the producer is granted NUM_STAGES acquires in a row without any consumer release.
- R4: A consumer wait on a stage is ready in the cycle after the commit that completes the stage's current filled round. Before that commit it stays blocked.
- R5: A producer acquire on a reused stage is blocked until the consumer releases that stage. It becomes ready in the cycle after that release.
- R6: A commit pulse while no producer acquisition is outstanding is ignored. A release pulse while no consumer wait is outstanding is ignored. Neither pulse changes any ready or stage output.
- R7: A consumer wait is never granted on the previous round's completion of a reused stage. `early_release` stays 0.
- R8: Commits and releases retire stages in the order in which their acquisitions or waits were granted.
- R9: A ready that is high while its valid is low stays high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_acq_valid | input | 1 | Producer requests the next stage |
| prod_acq_ready | output | 1 | Producer's current stage is drained for this lap |
| prod_stage | output | IW | Stage the next producer acquire will take |
| prod_commit | input | 1 | Producer finished filling its oldest acquired stage |
| cons_wait_valid | input | 1 | Consumer requests the next stage |
| cons_wait_ready | output | 1 | Consumer's current stage is filled for this lap |
| cons_stage | output | IW | Stage the next consumer wait will take |
| cons_release | input | 1 | Consumer finished with its oldest granted stage |
| early_release | output | 1 | Consumer grant issued on a stage whose current fill round is not complete |

## Verification
The bench builds the block with NUM_STAGES = 3, which is not a power of two. This checks that the wrap to zero comes from the explicit limit and not from counter overflow. Three stages also let both sides lap the ring several times in a short run. The table drives the point where the consumer meets a stage that completed once before but not again. That is the situation in which a missing phase toggle would let the wait through. The directed part streams twelve iterations and checks stray commit and release pulses.

// File: rtl/ring_seq_pkg.sv
`timescale 1ns/1ps
package ring_seq_pkg;

    // Expected phase each side loads at reset; opposite values let the
    // producer pass its first lap while the consumer blocks.
    localparam logic PROD_START_PHASE = 1'b1;
    localparam logic CONS_START_PHASE = 1'b0;

    typedef struct packed {
        logic valid;
        logic ready;
    } hshake_t;

    function automatic logic hs_fire(hshake_t h);
        return h.valid & h.ready;
    endfunction

    // Next stage number with an explicit wrap instead of a divider.
    function automatic int unsigned ring_next(int unsigned cur, int unsigned stages);
        return (cur == stages - 1) ? 0 : cur + 1;
    endfunction

    // A wait passes while the object's phase differs from the expectation.
    function automatic logic phase_pass(logic obj_phase, logic expect_phase);
        return obj_phase ^ expect_phase;
    endfunction

endpackage

// File: rtl/ring_side_cursor.sv
`timescale 1ns/1ps
module ring_side_cursor
    import ring_seq_pkg::*;
#(
    parameter int unsigned STAGES     = 4,
    parameter logic        START_PH   = 1'b0,
    localparam int unsigned IW        = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              grant,
    output logic [IW-1:0]     idx,
    output logic [STAGES-1:0] expect_ph
);

    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (grant) begin
            idx_q <= IW'(ring_next(int'(idx_q), STAGES));
        end
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_phase
            logic ph_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    ph_q <= START_PH;
                end else if (grant && (idx_q == IW'(s))) begin
                    ph_q <= ~ph_q;
                end
            end
            assign expect_ph[s] = ph_q;
        end
    endgenerate

    assign idx = idx_q;

    p_idx_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (grant && idx_q == IW'(STAGES - 1)) |=> (idx_q == '0));

    p_idx_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !grant |=> $stable(idx_q));

endmodule

// File: rtl/ring_retire_ptr.sv
`timescale 1ns/1ps
module ring_retire_ptr
    import ring_seq_pkg::*;
#(
    parameter int unsigned STAGES = 4,
    localparam int unsigned IW    = (STAGES > 1) ? $clog2(STAGES) : 1,
    localparam int unsigned CW    = $clog2(STAGES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          grant,
    input  logic          retire_req,
    output logic          retire_fire,
    output logic [IW-1:0] retire_idx
);

    logic [IW-1:0] ptr_q;
    logic [CW-1:0] open_q;

    // Only stages already granted and not yet retired may be retired.
    assign retire_fire = retire_req && (open_q != '0);
    assign retire_idx  = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            open_q <= '0;
        end else begin
            if (retire_fire) begin
                ptr_q <= IW'(ring_next(int'(ptr_q), STAGES));
            end
            case ({grant, retire_fire})
                2'b10:   open_q <= open_q + 1'b1;
                2'b01:   open_q <= open_q - 1'b1;
                default: open_q <= open_q;
            endcase
        end
    end

    p_stray_retire_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (retire_req && open_q == '0) |=> $stable(ptr_q));

    p_open_bounded_r8: assert property (@(posedge clk) disable iff (rst)
        open_q <= CW'(STAGES));

endmodule

// File: rtl/ring_stage_objects.sv
`timescale 1ns/1ps
module ring_stage_objects #(
    parameter int unsigned STAGES = 4,
    localparam int unsigned IW    = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              round_done,
    input  logic [IW-1:0]     round_idx,
    output logic [STAGES-1:0] obj_phase
);

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_obj
            logic ph_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    ph_q <= 1'b0;
                end else if (round_done && (round_idx == IW'(s))) begin
                    ph_q <= ~ph_q;
                end
            end
            assign obj_phase[s] = ph_q;
        end
    endgenerate

    p_one_flip_per_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(obj_phase ^ $past(obj_phase)) <= 1);

endmodule

// File: rtl/ring_round_audit.sv
`timescale 1ns/1ps
module ring_round_audit #(
    parameter int unsigned STAGES = 4,
    localparam int unsigned IW    = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fill_done,
    input  logic [IW-1:0] fill_idx,
    input  logic          take,
    input  logic [IW-1:0] take_idx,
    output logic          early
);

    // Per stage: completed fill rounds against consumer grants, modulo 4.
    logic [STAGES-1:0][1:0] fills_q;
    logic [STAGES-1:0][1:0] takes_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_cnt
            always_ff @(posedge clk) begin
                if (rst) begin
                    fills_q[s] <= '0;
                    takes_q[s] <= '0;
                end else begin
                    if (fill_done && fill_idx == IW'(s)) fills_q[s] <= fills_q[s] + 2'd1;
                    if (take && take_idx == IW'(s))      takes_q[s] <= takes_q[s] + 2'd1;
                end
            end
        end
    endgenerate

    assign early = take && (fills_q[take_idx] == takes_q[take_idx]);

endmodule

// File: rtl/ring_phase_seq.sv
`timescale 1ns/1ps
module ring_phase_seq
    import ring_seq_pkg::*;
#(
    parameter int unsigned NUM_STAGES = 4,
    localparam int unsigned IW        = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prod_acq_valid,
    output logic          prod_acq_ready,
    output logic [IW-1:0] prod_stage,
    input  logic          prod_commit,
    input  logic          cons_wait_valid,
    output logic          cons_wait_ready,
    output logic [IW-1:0] cons_stage,
    input  logic          cons_release,
    output logic          early_release
);

    logic [NUM_STAGES-1:0] filled_ph, drained_ph;
    logic [NUM_STAGES-1:0] prod_exp, cons_exp;
    logic [IW-1:0]         p_idx, c_idx;
    logic [IW-1:0]         commit_idx, release_idx;
    logic                  commit_fire, release_fire;
    hshake_t               p_hs, c_hs;
    logic                  p_grant, c_grant;

    assign p_hs.valid = prod_acq_valid;
    assign p_hs.ready = phase_pass(drained_ph[p_idx], prod_exp[p_idx]);
    assign c_hs.valid = cons_wait_valid;
    assign c_hs.ready = phase_pass(filled_ph[c_idx], cons_exp[c_idx]);
    assign p_grant    = hs_fire(p_hs);
    assign c_grant    = hs_fire(c_hs);

    ring_side_cursor #(.STAGES(NUM_STAGES), .START_PH(PROD_START_PHASE)) u_prod_cur (
        .clk(clk), .rst(rst), .grant(p_grant), .idx(p_idx), .expect_ph(prod_exp)
    );

    ring_side_cursor #(.STAGES(NUM_STAGES), .START_PH(CONS_START_PHASE)) u_cons_cur (
        .clk(clk), .rst(rst), .grant(c_grant), .idx(c_idx), .expect_ph(cons_exp)
    );

    ring_retire_ptr #(.STAGES(NUM_STAGES)) u_commit_ptr (
        .clk(clk), .rst(rst), .grant(p_grant), .retire_req(prod_commit),
        .retire_fire(commit_fire), .retire_idx(commit_idx)
    );

    ring_retire_ptr #(.STAGES(NUM_STAGES)) u_release_ptr (
        .clk(clk), .rst(rst), .grant(c_grant), .retire_req(cons_release),
        .retire_fire(release_fire), .retire_idx(release_idx)
    );

    ring_stage_objects #(.STAGES(NUM_STAGES)) u_filled (
        .clk(clk), .rst(rst), .round_done(commit_fire), .round_idx(commit_idx),
        .obj_phase(filled_ph)
    );

    ring_stage_objects #(.STAGES(NUM_STAGES)) u_drained (
        .clk(clk), .rst(rst), .round_done(release_fire), .round_idx(release_idx),
        .obj_phase(drained_ph)
    );

    ring_round_audit #(.STAGES(NUM_STAGES)) u_audit (
        .clk(clk), .rst(rst), .fill_done(commit_fire), .fill_idx(commit_idx),
        .take(c_grant), .take_idx(c_idx), .early(early_release)
    );

    assign prod_acq_ready  = p_hs.ready;
    assign cons_wait_ready = c_hs.ready;
    assign prod_stage      = p_idx;
    assign cons_stage      = c_idx;

    p_no_early_release_r7: assert property (@(posedge clk) disable iff (rst)
        !early_release);

    p_prod_ready_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (prod_acq_ready && !prod_acq_valid) |=> prod_acq_ready);

    p_cons_ready_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (cons_wait_ready && !cons_wait_valid) |=> cons_wait_ready);

    p_cons_ready_after_commit_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cons_wait_ready) |-> $past(prod_commit));

    p_prod_ready_after_release_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(prod_acq_ready) |-> $past(cons_release));

endmodule

// File: tb/ring_phase_seq_bench.sv
`timescale 1ns/1ps
module ring_phase_seq_bench;

    localparam int unsigned NS = 3;
    localparam int unsigned IW = 2;

    logic clk = 1'b0;
    logic rst;
    logic prod_acq_valid, prod_commit, cons_wait_valid, cons_release;
    logic prod_acq_ready, cons_wait_ready, early_release;
    logic [IW-1:0] prod_stage, cons_stage;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit monitor_on = 1'b0;

    always #2.5 clk = ~clk;

    ring_phase_seq #(.NUM_STAGES(NS)) u_ring_phase_seq (
        .clk(clk), .rst(rst),
        .prod_acq_valid(prod_acq_valid), .prod_acq_ready(prod_acq_ready),
        .prod_stage(prod_stage), .prod_commit(prod_commit),
        .cons_wait_valid(cons_wait_valid), .cons_wait_ready(cons_wait_ready),
        .cons_stage(cons_stage), .cons_release(cons_release),
        .early_release(early_release)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Vector: {acq, commit, wait, release, exp_pready, exp_cready, exp_pstage[1:0], exp_cstage[1:0]}
    // Expected values describe the outputs during the cycle the inputs are applied.
    localparam logic [9:0] VEC [20] = '{
        10'b0000_10_00_00, // R1 reset state
        10'b0010_10_00_00, // R4 wait blocks with nothing filled
        10'b1000_10_00_00, // R3 first lap, stage 0
        10'b1000_10_01_00, // R3 stage 1
        10'b1000_10_10_00, // R3 stage 2, wrap follows (R2)
        10'b1000_00_00_00, // R5 reused stage 0 blocked
        10'b0100_00_00_00, // commit stage 0
        10'b0010_01_00_00, // R4 ready one cycle after commit
        10'b0010_00_00_01, // R4 stage 1 still blocked
        10'b0001_00_00_01, // release stage 0
        10'b0001_10_00_01, // R5 ready after release; stray release ignored (R6)
        10'b0110_10_00_01, // commit stage 1 (R8 order)
        10'b1010_11_00_01, // both sides granted
        10'b0100_00_01_10, // commit stage 2
        10'b0100_01_01_10, // commit stage 0 second round
        10'b0100_01_01_10, // stray commit ignored (R6)
        10'b0011_01_01_10, // grant stage 2, release stage 1
        10'b0010_11_01_00, // stage 0 second round filled
        10'b0010_10_01_01, // R7 stage 1 filled once only: must block
        10'b0000_10_01_01  // R9 ready holds while idle
    };

    always @(negedge clk) begin
        if (monitor_on && !rst) begin
            #0.5;
            check(early_release == 1'b0, "R7 early_release", int'(early_release), 0);
        end
    end

    task automatic drive(input logic a, input logic c, input logic w, input logic r);
        prod_acq_valid  = a;
        prod_commit     = c;
        cons_wait_valid = w;
        cons_release    = r;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        drive(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        drive(0, 0, 0, 0);
        do_reset();
        monitor_on = 1'b1;

        // Table walk; rst was released at this negedge.
        for (int i = 0; i < 20; i++) begin
            if (i > 0) @(negedge clk);
            drive(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6]);
            #1;
            check(prod_acq_ready == VEC[i][5], $sformatf("R3 R5 prod ready vec %0d", i),
                  int'(prod_acq_ready), int'(VEC[i][5]));
            check(cons_wait_ready == VEC[i][4], $sformatf("R4 R7 cons ready vec %0d", i),
                  int'(cons_wait_ready), int'(VEC[i][4]));
            check(prod_stage == VEC[i][3:2], $sformatf("R2 prod stage vec %0d", i),
                  int'(prod_stage), int'(VEC[i][3:2]));
            check(cons_stage == VEC[i][1:0], $sformatf("R2 cons stage vec %0d", i),
                  int'(cons_stage), int'(VEC[i][1:0]));
        end

        // R1: reset in the middle of activity restores the start state.
        do_reset();
        #1;
        check(prod_acq_ready == 1'b1, "R1 prod ready", int'(prod_acq_ready), 1);
        check(cons_wait_ready == 1'b0, "R1 cons ready", int'(cons_wait_ready), 0);
        check(prod_stage == '0, "R1 prod stage", int'(prod_stage), 0);
        check(cons_stage == '0, "R1 cons stage", int'(cons_stage), 0);
        check(early_release == 1'b0, "R1 early_release", int'(early_release), 0);

        // R6: stray commit and release pulses before any grant.
        drive(0, 1, 0, 1);
        @(negedge clk);
        drive(0, 0, 0, 0);
        #1;
        check(cons_wait_ready == 1'b0, "R6 stray commit", int'(cons_wait_ready), 0);
        check(prod_acq_ready == 1'b1, "R6 stray release", int'(prod_acq_ready), 1);
        check(prod_stage == '0, "R6 prod stage", int'(prod_stage), 0);

        // R2 R8: stream twelve iterations, one stage at a time.
        for (int it = 0; it < 12; it++) begin
            @(negedge clk);
            drive(1, 0, 0, 0);
            #1;
            check(prod_acq_ready == 1'b1, "R5 stream prod ready", int'(prod_acq_ready), 1);
            check(prod_stage == IW'(it % NS), "R2 stream prod stage", int'(prod_stage), it % NS);
            @(negedge clk);
            drive(0, 1, 0, 0);
            #1;
            check(cons_wait_ready == 1'b0, "R4 stream cons blocked", int'(cons_wait_ready), 0);
            @(negedge clk);
            drive(0, 0, 1, 0);
            #1;
            check(cons_wait_ready == 1'b1, "R4 stream cons ready", int'(cons_wait_ready), 1);
            check(cons_stage == IW'(it % NS), "R8 stream cons stage", int'(cons_stage), it % NS);
            @(negedge clk);
            drive(0, 0, 0, 1);
            @(negedge clk);
            drive(0, 0, 0, 0);
            #1;
            check(cons_wait_ready == 1'b0, "R7 stream cons idle", int'(cons_wait_ready), 0);
        end

        @(negedge clk);
        monitor_on = 1'b0;
        finish_up();
    end

    initial begin
        #(5.0 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule